// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block sits between a read requester and one bank of synchronous DRAM. It turns a single read request into the command pins and multiplexed address that the memory expects. A request carries a row address, a column address and a burst-order select. The block first opens the row if needed: it closes a different open row first, then activates the wanted one. It waits out the row-to-column delay and issues the column read. It then marks each clock cycle in which the memory returns a beat of the burst, and tags each beat with the column it belongs to.

The last row stays open, so a later read to the same row goes straight to the column command. An internal interval counter schedules periodic refresh. A pending refresh is served only while no burst is running, and it takes priority over a waiting request. All timing gaps are compile-time parameters.

The request side is a valid/ready handshake. The requester holds `req_valid` and the request fields steady until a cycle in which `req_ready` is high; the request is taken at the end of that cycle. `req_ready` is high only while the sequencer is idle and no refresh is waiting. The read beats cannot be stalled, because the memory drives them at a fixed latency, so `rd_valid` carries no ready.

Top module: `sdr_read_seq`

## Requirements
- R1: On a read to a closed row, ACTIVATE (cs_n=0, ras_n=0, cas_n=1, we_n=1, address = row) is driven in the cycle after acceptance. READ (cs_n=0, ras_n=1, cas_n=0, we_n=1, address = column zero-extended) follows exactly T_RCD (default 2) cycles later.
- R2: `rd_valid` rises exactly CAS_LAT (default 2) cycles after the READ cycle and stays high for exactly BURST_LEN (default 4) consecutive cycles.
- R3: During beat i (0-based), `rd_col` keeps the start column bits above the low log2(BURST_LEN) bits. With `req_ilv`=0 the low bits are (start_low + i) mod BURST_LEN. With `req_ilv`=1 they are start_low XOR i.
- R4: A read to the row that is already open issues READ in the cycle after acceptance, with no PRECHARGE or ACTIVATE.
- R5: A read to a different row while a row is open issues PRECHARGE (cs_n=0, ras_n=0, cas_n=1, we_n=0, address 0) in the cycle after acceptance, then ACTIVATE exactly T_RP (default 2) cycles later.
- R6: A refresh becomes pending after every REF_INTERVAL (default 780) clock edges since reset. It is served only when idle, ahead of any request. An open row is precharged first, then AUTO REFRESH (cs_n=0, ras_n=0, cas_n=0, we_n=1, address 0) is issued, with the same T_RP gap after the precharge.
- R7: After AUTO REFRESH the block stays busy for T_RFC (default 4) cycles in total. All rows are then closed, so the next read activates.
- R8: Every cycle without a command drives NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, address 0). `busy` is high from the first command cycle of a sequence through its last cycle. `req_ready` equals not-busy and no refresh pending.
- R9: During reset the pins show NOP, and `busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request taken at end of this cycle if valid |
| req_row | input | ROW_W | Row to read |
| req_col | input | COL_W | Start column of the burst |
| req_ilv | input | 1 | 1 = interleaved burst order, 0 = sequential |
| busy | output | 1 | A command sequence is in progress |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| rd_valid | output | 1 | This cycle carries a read beat |
| rd_col | output | COL_W | Column of the current beat (0 when no beat) |

## Verification
A refresh interval can expire in the same cycle that a request is waiting at an idle sequencer. The interval can also expire in the cycle a request is accepted. The bench provokes both by streaming back-to-back requests across the second refresh boundary, with `req_valid` held high. A cycle model in the bench decides independently, for every idle cycle, whether refresh or the request wins. It compares pins, address, beat marks, columns, `busy` and `req_ready` on every clock. This shows that the request is deferred, not lost, and that it then reopens its row after the refresh.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_RD,
    ST_DATA,
    ST_REF,
    ST_GAP
  } seq_st_e;

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int unsigned INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic pend
);
  localparam int unsigned CW = $clog2(INTERVAL);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !clr |=> pend); // R6

endmodule

// File: rtl/sdr_burst_order.sv
module sdr_burst_order #(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BEAT_W = 2
) (
  input  logic [COL_W-1:0]  start_col,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ilv,
  output logic [COL_W-1:0]  col
);
  logic [BEAT_W-1:0] low;

  always_comb begin
    if (ilv) low = start_col[BEAT_W-1:0] ^ beat;
    else     low = start_col[BEAT_W-1:0] + beat;
  end

  generate
    if (COL_W > BEAT_W) begin : g_keep_high
      assign col = {start_col[COL_W-1:BEAT_W], low};
    end else begin : g_low_only
      assign col = low;
    end
  endgenerate

endmodule

// File: rtl/sdr_read_seq.sv
module sdr_read_seq
  import sdr_rd_pkg::*;
#(
  parameter int unsigned ROW_W        = 12,
  parameter int unsigned COL_W        = 8,
  parameter int unsigned BURST_LEN    = 4,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned CAS_LAT      = 2,
  parameter int unsigned T_RP         = 2,
  parameter int unsigned T_RFC        = 4,
  parameter int unsigned REF_INTERVAL = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_ilv,
  output logic             busy,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [ROW_W-1:0] sd_addr,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col
);
  localparam int unsigned BEAT_W    = $clog2(BURST_LEN);
  localparam int unsigned DATA_LAST = CAS_LAT + BURST_LEN - 2;
  localparam int unsigned G1        = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int unsigned G2        = (G1 > T_RFC) ? G1 : T_RFC;
  localparam int unsigned GAP_MAX   = (G2 > DATA_LAST + 1) ? G2 : DATA_LAST + 1;
  localparam int unsigned CNT_W     = $clog2(GAP_MAX + 1);
  localparam int unsigned SW        = CNT_W + 1;

  seq_st_e          state, ret_st;
  logic [CNT_W-1:0] wcnt;
  logic             row_open, do_ref, lat_ilv;
  logic [ROW_W-1:0] open_row, lat_row;
  logic [COL_W-1:0] lat_col;
  logic             ref_pend, ref_clr;
  sdr_cmd_e         cmd;
  logic [CNT_W-1:0] beat_full;
  logic [COL_W-1:0] beat_col;

  sdr_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ref_clr),
    .pend (ref_pend)
  );

  assign ref_clr   = (state == ST_REF);
  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE) && !ref_pend;

  // command decode
  always_comb begin
    unique case (state)
      ST_PRE:  cmd = CMD_PRE;
      ST_ACT:  cmd = CMD_ACT;
      ST_RD:   cmd = CMD_RD;
      ST_REF:  cmd = CMD_REF;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_comb begin
    unique case (state)
      ST_ACT:  sd_addr = lat_row;
      ST_RD:   sd_addr = ROW_W'(lat_col);
      default: sd_addr = '0;
    endcase
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ret_st   <= ST_IDLE;
      wcnt     <= '0;
      row_open <= 1'b0;
      open_row <= '0;
      lat_row  <= '0;
      lat_col  <= '0;
      lat_ilv  <= 1'b0;
      do_ref   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            do_ref <= 1'b1;
            state  <= row_open ? ST_PRE : ST_REF;
          end else if (req_valid) begin
            lat_row <= req_row;
            lat_col <= req_col;
            lat_ilv <= req_ilv;
            if (row_open && open_row == req_row) state <= ST_RD;
            else if (row_open)                   state <= ST_PRE;
            else                                 state <= ST_ACT;
          end
        end
        ST_PRE: begin
          row_open <= 1'b0;
          if (T_RP > 1) begin
            state  <= ST_GAP;
            ret_st <= do_ref ? ST_REF : ST_ACT;
            wcnt   <= CNT_W'(T_RP - 1);
          end else begin
            state  <= do_ref ? ST_REF : ST_ACT;
          end
        end
        ST_ACT: begin
          row_open <= 1'b1;
          open_row <= lat_row;
          if (T_RCD > 1) begin
            state  <= ST_GAP;
            ret_st <= ST_RD;
            wcnt   <= CNT_W'(T_RCD - 1);
          end else begin
            state  <= ST_RD;
          end
        end
        ST_RD: begin
          state <= ST_DATA;
          wcnt  <= '0;
        end
        ST_DATA: begin
          if (wcnt == CNT_W'(DATA_LAST)) state <= ST_IDLE;
          else                           wcnt  <= wcnt + 1'b1;
        end
        ST_REF: begin
          do_ref <= 1'b0;
          if (T_RFC > 1) begin
            state  <= ST_GAP;
            ret_st <= ST_IDLE;
            wcnt   <= CNT_W'(T_RFC - 1);
          end else begin
            state  <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (wcnt == CNT_W'(1)) state <= ret_st;
          else                   wcnt  <= wcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read beats
  assign rd_valid  = (state == ST_DATA) && (wcnt >= CNT_W'(CAS_LAT - 1));
  assign beat_full = wcnt - CNT_W'(CAS_LAT - 1);

  sdr_burst_order #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_burst_order (
    .start_col(lat_col),
    .beat     (beat_full[BEAT_W-1:0]),
    .ilv      (lat_ilv),
    .col      (beat_col)
  );

  assign rd_col = rd_valid ? beat_col : '0;

  // cycle distance to the last command of each kind, for the checks below
  logic [SW-1:0] since_act, since_pre, since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      since_rd  <= '1;
    end else begin
      since_act <= (cmd == CMD_ACT) ? SW'(1) : ((since_act == '1) ? since_act : since_act + 1'b1);
      since_pre <= (cmd == CMD_PRE) ? SW'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
      since_rd  <= (cmd == CMD_RD)  ? SW'(1) : ((since_rd  == '1) ? since_rd  : since_rd  + 1'b1);
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_RD |-> since_act >= SW'(T_RCD)); // R1
  AST_DV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> since_rd == SW'(CAS_LAT)); // R2
  AST_DV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && since_rd == SW'(CAS_LAT + BURST_LEN - 1) |=> !rd_valid); // R2
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT || cmd == CMD_REF) |-> since_pre >= SW'(T_RP)); // R5
  AST_REF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_REF |-> !row_open); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == CMD_NOP) && !rd_valid && sd_addr == '0); // R8

endmodule

// File: tb/test_sdr_read_seq.sv
module test_sdr_read_seq;
  localparam int CLK_PERIOD   = 10;
  localparam int ROW_W        = 12;
  localparam int COL_W        = 8;
  localparam int BURST_LEN    = 4;
  localparam int T_RCD        = 2;
  localparam int CAS_LAT      = 2;
  localparam int T_RP         = 2;
  localparam int T_RFC        = 4;
  localparam int REF_INTERVAL = 780;

  // pin codes {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] E_NOP = 4'b0111;
  localparam logic [3:0] E_ACT = 4'b0011;
  localparam logic [3:0] E_RD  = 4'b0101;
  localparam logic [3:0] E_PRE = 4'b0010;
  localparam logic [3:0] E_REF = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ilv = 1'b0;
  logic busy, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rd_valid;
  logic [ROW_W-1:0] sd_addr;
  logic [COL_W-1:0] rd_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_read_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD),
    .CAS_LAT(CAS_LAT), .T_RP(T_RP), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)
  ) i_sdr_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_ilv(req_ilv), .busy(busy),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .rd_valid(rd_valid), .rd_col(rd_col)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  int k = 0;
  bit pend = 0;
  bit m_open = 0;
  int m_row = 0;
  logic [3:0] q_cmd[$];
  int q_addr[$];
  bit q_dv[$];
  int q_col[$];
  string q_tag[$];
  logic [3:0] c_cmd = E_NOP;
  int c_addr = 0;
  bit c_dv = 0;
  int c_col = 0;
  bit c_busy = 0;
  string c_tag = "R8";

  function automatic int col_of(int start, int i, bit ilv);
    int low;
    if (ilv) low = (start % BURST_LEN) ^ i;
    else     low = ((start % BURST_LEN) + i) % BURST_LEN;
    return (start / BURST_LEN) * BURST_LEN + low;
  endfunction

  task automatic push(logic [3:0] cmd, int addr, bit dv, int col, string tag);
    q_cmd.push_back(cmd); q_addr.push_back(addr); q_dv.push_back(dv);
    q_col.push_back(col); q_tag.push_back(tag);
  endtask

  task automatic plan_read(int r, int c, bit ilv);
    if (m_open && m_row == r) begin
      push(E_RD, c, 0, 0, "R4");
    end else begin
      if (m_open) begin
        push(E_PRE, 0, 0, 0, "R5");
        for (int j = 1; j < T_RP; j++) push(E_NOP, 0, 0, 0, "R5");
      end
      push(E_ACT, r, 0, 0, "R1");
      for (int j = 1; j < T_RCD; j++) push(E_NOP, 0, 0, 0, "R1");
      push(E_RD, c, 0, 0, "R1");
    end
    for (int j = 0; j < CAS_LAT + BURST_LEN - 1; j++) begin
      if (j >= CAS_LAT - 1) push(E_NOP, 0, 1, col_of(c, j - (CAS_LAT - 1), ilv), "R2 R3");
      else                  push(E_NOP, 0, 0, 0, "R2");
    end
    m_open = 1;
    m_row = r;
  endtask

  task automatic plan_refresh();
    if (m_open) begin
      push(E_PRE, 0, 0, 0, "R6");
      for (int j = 1; j < T_RP; j++) push(E_NOP, 0, 0, 0, "R6");
    end
    push(E_REF, 0, 0, 0, "R6");
    for (int j = 1; j < T_RFC; j++) push(E_NOP, 0, 0, 0, "R7");
    m_open = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; pend = 0; m_open = 0; m_row = 0;
      q_cmd.delete(); q_addr.delete(); q_dv.delete(); q_col.delete(); q_tag.delete();
      c_cmd = E_NOP; c_addr = 0; c_dv = 0; c_col = 0; c_busy = 0; c_tag = "R9";
    end else begin
      k++;
      if (!c_busy) begin
        if (pend)           plan_refresh();
        else if (req_valid) plan_read(int'(req_row), int'(req_col), req_ilv);
      end
      if (c_cmd == E_REF) pend = 0;
      if (k % REF_INTERVAL == 0) pend = 1;
      if (q_cmd.size() > 0) begin
        c_cmd = q_cmd.pop_front(); c_addr = q_addr.pop_front(); c_dv = q_dv.pop_front();
        c_col = q_col.pop_front(); c_tag = q_tag.pop_front(); c_busy = 1;
      end else begin
        c_cmd = E_NOP; c_addr = 0; c_dv = 0; c_col = 0; c_busy = 0; c_tag = "R8";
      end
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, got, exp, k);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk("R9", "pins in reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(E_NOP));
        chk("R9", "busy in reset", int'(busy), 0);
        chk("R9", "rd_valid in reset", int'(rd_valid), 0);
      end else begin
        chk(c_tag, "command pins", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(c_cmd));
        chk(c_tag, "address", int'(sd_addr), c_addr);
        chk("R2", "rd_valid", int'(rd_valid), int'(c_dv));
        if (c_dv) chk("R3", "beat column", int'(rd_col), c_col);
        chk("R8", "busy", int'(busy), int'(c_busy));
        chk("R8 R6", "req_ready", int'(req_ready), int'(!c_busy && !pend));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(int r, int c, bit ilv);
    req_valid = 1'b1;
    req_row = ROW_W'(r);
    req_col = COL_W'(c);
    req_ilv = ilv;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(2);
    do_req(5, 8, 0);          // R1 closed row, sequential from aligned column
    idle_cycles(3);
    do_req(5, 11, 0);         // R4 page hit, R3 wrap 11,8,9,10
    do_req(5, 13, 1);         // R3 interleaved 13,12,15,14
    do_req(5, 13, 0);         // R3 sequential 13,14,15,12
    do_req(9, 2, 1);          // R5 row change
    while (k < REF_INTERVAL + 20) @(negedge clk); // R6 first refresh with row open
    do_req(9, 4, 0);          // R7 row closed by refresh
    while (k < 2 * REF_INTERVAL - 60) @(negedge clk);
    for (int i = 0; i < 24; i++) do_req(i % 3, (i * 5) % 256, i[0]); // R6 collision stream
    idle_cycles(20);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: got hang expected completion");
    finish_run();
  end

endmodule